// File: doc/BRIEF.md
# Nonvolatile Byte Access Controller

This block sits between a small CPU register bus and an on-chip nonvolatile byte array. Software sees three registers: an address register, a data register and a control register. Reads are single-byte, strobed and complete at once from the program's point of view. Writes are two-step and timed: software first arms the write, then sets the write strobe shortly after.

While the block works it raises a stall output for a fixed number of CPU cycles. Write duration is counted on a separate slow timing clock, so it does not depend on the CPU clock rate. The completion count crosses back into the CPU clock domain through a toggle synchronizer. The address and data registers are frozen for the whole write. The array byte is committed from those frozen registers when the programming time has run out.

Registers are chosen by `bus_sel_i`: 0 is the address, 1 is the data and 2 is the control. Control bits are: bit 0 read strobe, bit 1 write strobe/busy, and bit 2 write arm.

Top module: `nvm_access_ctrl`

## Requirements
- R1: After reset, the address, data and control registers read 0, `stall_o` is 0, and the array sees no access.
- R2: Writing control bit 2 (without bit 1) arms a write. The arm bit reads back as 1 and clears by itself after ARM_CYC (4) CPU cycles.
- R3: A control write with bit 1 set starts a write only if the arm bit is still 1 in the cycle that write is sampled. The window covers up to the 4th cycle after the arm write; from the 5th cycle on, the request is dropped and the array is untouched.
- R4: A write that starts drives `stall_o` high for exactly WR_STALL (2) CPU cycles.
- R5: While a write is in progress, control bit 1 reads 1. It returns to 0 only after WR_TICKS timing-clock cycles (default 8448) plus the synchronizer delay. At that point the array byte at the held address holds the held data.
- R6: A control write with bit 0 set loads the data register from the array at the current address, with the data visible within 2 cycles. It drives `stall_o` high for exactly RD_STALL (4) CPU cycles. Control bit 0 always reads 0.
- R7: While a write is busy, read strobes are ignored (no stall, data register unchanged), and writes to the address or data register have no effect.
- R8: A control write with bit 1 set clears the arm bit at once, whether or not the write starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| tck_i | input | 1 | Slow write-timing clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| bus_we_i | input | 1 | Register write strobe |
| bus_sel_i | input | 2 | Register select (0 address, 1 data, 2 control) |
| bus_wdata_i | input | DATA_W | Register write data |
| bus_rdata_o | output | DATA_W | Register read data for `bus_sel_i` |
| stall_o | output | 1 | CPU stall request |
| arr_addr_o | output | ADDR_W | Array address |
| arr_wdata_o | output | DATA_W | Array write data |
| arr_we_o | output | 1 | Array write strobe (one cycle at write completion) |
| arr_re_o | output | 1 | Array read strobe (synchronous, data next cycle) |
| arr_rdata_i | input | DATA_W | Array read data |

## Verification
The hardest case to reach is the edge of the arm window. A write strobe sampled in the 4th cycle after arming must start a write, and one sampled in the 5th must not. The bench places the strobe at an exact cycle offset from the arm write, on both sides of the boundary. The register-lock rules only apply during a write that lasts many CPU cycles. So the bench starts a write with a reduced tick count, then hits the address, data and read strobe while busy reads 1. Afterwards it confirms from the ports that the held address and data reached the array.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2
  } nvm_sel_e;

  localparam int unsigned CTL_REN = 0;
  localparam int unsigned CTL_WEN = 1;
  localparam int unsigned CTL_ARM = 2;
endpackage

// File: rtl/nvm_tgl_sync.sv
module nvm_tgl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/nvm_wr_timer.sv
module nvm_wr_timer #(
  parameter int unsigned WR_TICKS    = 8448,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic start_tgl_i,
  output logic done_tgl_o
);
  localparam int unsigned CNT_W = $clog2(WR_TICKS + 1);

  logic             start_s, start_d_q, start_pulse;
  logic             run_q, done_q;
  logic [CNT_W-1:0] cnt_q;

  nvm_tgl_sync #(.STAGES(SYNC_STAGES)) i_start_sync (
    .clk_i (tck_i),
    .rst_ni(rst_ni),
    .d_i   (start_tgl_i),
    .q_o   (start_s)
  );

  assign start_pulse = start_s ^ start_d_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_d_q <= 1'b0;
      run_q     <= 1'b0;
      done_q    <= 1'b0;
      cnt_q     <= '0;
    end else begin
      start_d_q <= start_s;
      if (start_pulse) begin
        run_q <= 1'b1;
        cnt_q <= CNT_W'(WR_TICKS);
      end else if (run_q) begin
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= ~done_q;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign done_tgl_o = done_q;

  // R5
  tick_bound_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WR_TICKS));
  // R5
  no_restart_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    start_pulse |-> !run_q);
endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl
  import nvm_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WR_TICKS    = 8448,
  parameter int unsigned ARM_CYC     = 4,
  parameter int unsigned RD_STALL    = 4,
  parameter int unsigned WR_STALL    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_sel_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              stall_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  output logic              arr_we_o,
  output logic              arr_re_o,
  input  logic [DATA_W-1:0] arr_rdata_i
);
  localparam int unsigned ST_MAX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
  localparam int unsigned ST_W   = $clog2(ST_MAX + 1);
  localparam int unsigned ARM_W  = $clog2(ARM_CYC + 1);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              arm_q, busy_q, rd_pend_q, req_tgl_q;
  logic [ARM_W-1:0]  arm_cnt_q;
  logic [ST_W-1:0]   stall_cnt_q;
  logic              done_tgl, done_s, done_d_q, done_pulse;
  logic              ctrl_wr, wen_req, ren_req, arm_req, wr_go, rd_go;
  logic [DATA_W-1:0] ctrl_rd;

  assign ctrl_wr = bus_we_i && (bus_sel_i == SEL_CTRL);
  assign wen_req = ctrl_wr && bus_wdata_i[CTL_WEN];
  assign ren_req = ctrl_wr && bus_wdata_i[CTL_REN] && !wen_req;
  assign arm_req = ctrl_wr && bus_wdata_i[CTL_ARM] && !wen_req;
  assign wr_go   = wen_req && arm_q && !busy_q;
  assign rd_go   = ren_req && !busy_q;

  // arm window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q     <= 1'b0;
      arm_cnt_q <= '0;
    end else if (wen_req) begin
      arm_q     <= 1'b0;
      arm_cnt_q <= '0;
    end else if (arm_req) begin
      arm_q     <= 1'b1;
      arm_cnt_q <= ARM_W'(ARM_CYC);
    end else if (arm_q) begin
      if (arm_cnt_q == ARM_W'(1)) begin
        arm_q     <= 1'b0;
        arm_cnt_q <= '0;
      end else begin
        arm_cnt_q <= arm_cnt_q - ARM_W'(1);
      end
    end
  end

  nvm_wr_timer #(.WR_TICKS(WR_TICKS), .SYNC_STAGES(SYNC_STAGES)) i_wr_timer (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .start_tgl_i(req_tgl_q),
    .done_tgl_o (done_tgl)
  );

  nvm_tgl_sync #(.STAGES(SYNC_STAGES)) i_done_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (done_tgl),
    .q_o   (done_s)
  );

  assign done_pulse = done_s ^ done_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_tgl_q   <= 1'b0;
      done_d_q    <= 1'b0;
      busy_q      <= 1'b0;
      stall_cnt_q <= '0;
      rd_pend_q   <= 1'b0;
    end else begin
      done_d_q  <= done_s;
      rd_pend_q <= rd_go;
      if (wr_go) begin
        req_tgl_q <= ~req_tgl_q;
        busy_q    <= 1'b1;
      end else if (done_pulse) begin
        busy_q <= 1'b0;
      end
      if (wr_go)                  stall_cnt_q <= ST_W'(WR_STALL);
      else if (rd_go)             stall_cnt_q <= ST_W'(RD_STALL);
      else if (stall_cnt_q != '0) stall_cnt_q <= stall_cnt_q - ST_W'(1);
    end
  end

  // locked while busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (bus_we_i && bus_sel_i == SEL_ADDR && !busy_q)
        addr_q <= bus_wdata_i[ADDR_W-1:0];
      if (rd_pend_q)
        data_q <= arr_rdata_i;
      else if (bus_we_i && bus_sel_i == SEL_DATA && !busy_q)
        data_q <= bus_wdata_i;
    end
  end

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[CTL_ARM] = arm_q;
    ctrl_rd[CTL_WEN] = busy_q;
    case (bus_sel_i)
      SEL_ADDR: bus_rdata_o = DATA_W'(addr_q);
      SEL_DATA: bus_rdata_o = data_q;
      SEL_CTRL: bus_rdata_o = ctrl_rd;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign stall_o     = (stall_cnt_q != '0);
  assign arr_addr_o  = addr_q;
  assign arr_wdata_o = data_q;
  assign arr_re_o    = rd_go;
  assign arr_we_o    = done_pulse && busy_q;

  // R7
  addr_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_q) |-> $stable(addr_q));
  // R7
  data_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_q) |-> $stable(data_q));
  // R4
  stall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(ctrl_wr));
  // R6
  stall_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_cnt_q <= ST_W'(ST_MAX));
  // R2
  arm_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_cnt_q <= ARM_W'(ARM_CYC));
  // R5
  done_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pulse |-> busy_q);
endmodule

// File: tb/test_nvm_access_ctrl.sv
module test_nvm_access_ctrl;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned TICKS  = 16;
  localparam int unsigned RATIO  = 4;   // tck period / clk period

  logic              clk_i = 1'b0, tck_i = 1'b0, rst_ni = 1'b0;
  logic              bus_we_i = 1'b0;
  logic [1:0]        bus_sel_i = 2'd0;
  logic [DATA_W-1:0] bus_wdata_i = '0;
  logic [DATA_W-1:0] bus_rdata_o, arr_wdata_o, arr_rdata_i;
  logic [ADDR_W-1:0] arr_addr_o;
  logic              stall_o, arr_we_o, arr_re_o;

  int checks = 0, errors = 0;
  logic [DATA_W-1:0] mem [256];
  logic [DATA_W-1:0] exp_mem [256];

  always #5  clk_i = ~clk_i;
  always #20 tck_i = ~tck_i;

  nvm_access_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_TICKS(TICKS)) i_nvm_access_ctrl (
    .clk_i, .tck_i, .rst_ni, .bus_we_i, .bus_sel_i, .bus_wdata_i, .bus_rdata_o,
    .stall_o, .arr_addr_o, .arr_wdata_o, .arr_we_o, .arr_re_o, .arr_rdata_i
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      arr_rdata_i <= '0;
    end else begin
      if (arr_we_o) mem[arr_addr_o] <= arr_wdata_o;
      if (arr_re_o) arr_rdata_i <= mem[arr_addr_o];
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; captured at the next posedge, returns at the following negedge
  task automatic bus_wr(logic [1:0] sel, logic [7:0] d);
    bus_we_i = 1'b1; bus_sel_i = sel; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [7:0] v);
    bus_sel_i = sel; #1; v = bus_rdata_o;
  endtask

  task automatic stall_len(output int n);
    n = 0;
    while (stall_o && n < 20) begin n++; @(negedge clk_i); end
  endtask

  task automatic wait_idle(output int cyc);
    logic [7:0] c;
    cyc = 0;
    rd(2, c);
    while (c[1] && cyc < 2000) begin
      @(negedge clk_i); cyc++; rd(2, c);
    end
  endtask

  task automatic do_read(logic [7:0] a, string tag);
    logic [7:0] v; int n;
    bus_wr(0, a);
    bus_wr(2, 8'h01);
    stall_len(n);
    chk({tag, " stall"}, n, 4);
    rd(1, v); chk({tag, " data"}, v, exp_mem[a]);
    rd(2, v); chk({tag, " strobe readback"}, v[0], 0);
  endtask

  task automatic do_write(logic [7:0] a, logic [7:0] d, int gap, string tag);
    logic [7:0] v; int n, cyc;
    bus_wr(0, a);
    bus_wr(1, d);
    bus_wr(2, 8'h04);
    repeat (gap - 1) @(negedge clk_i);
    bus_wr(2, 8'h02);
    stall_len(n);
    if (gap <= 4) begin
      chk({tag, " R4 write stall"}, n, 2);
      rd(2, v); chk({tag, " R3 busy set"}, v[1], 1);
      chk({tag, " R8 arm cleared"}, v[2], 0);
      wait_idle(cyc);
      checks++;
      if (cyc < int'(TICKS * RATIO) - 2 || cyc > int'(TICKS * RATIO) + 24) begin
        errors++;
        $display("FAIL %s R5 busy length act=%0d exp=%0d..%0d", tag, cyc,
                 TICKS * RATIO - 2, TICKS * RATIO + 24);
      end
      exp_mem[a] = d;
    end else begin
      chk({tag, " R3 late strobe no stall"}, n, 0);
      rd(2, v); chk({tag, " R3 late strobe not busy"}, v[1], 0);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v; int n, cyc;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) exp_mem[i] = pat(i);
    repeat (4) @(negedge clk_i);
    // R1 reset state
    rd(0, v); chk("R1 addr", v, 0);
    rd(1, v); chk("R1 data", v, 0);
    rd(2, v); chk("R1 ctrl", v, 0);
    chk("R1 stall", stall_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 arm self clear after 4 cycles
    bus_wr(2, 8'h04);
    rd(2, v); chk("R2 arm set", v[2], 1);
    repeat (3) @(negedge clk_i);
    rd(2, v); chk("R2 arm still set cycle 4", v[2], 1);
    @(negedge clk_i);
    rd(2, v); chk("R2 arm expired", v[2], 0);

    // R6 directed reads
    do_read(8'h00, "R6 rd0");
    do_read(8'hFF, "R6 rdFF");

    // R3 window edges
    do_write(8'h21, 8'hC3, 4, "R3 gap4");
    do_read(8'h21, "R5 readback gap4");
    do_write(8'h22, 8'h3C, 5, "R3 gap5");
    do_read(8'h22, "R3 untouched gap5");
    do_write(8'h23, 8'h99, 1, "R3 gap1");
    do_read(8'h23, "R5 readback gap1");

    // R8 strobe without arm
    bus_wr(2, 8'h02);
    rd(2, v); chk("R8 no arm no busy", v[1], 0);

    // R7 lock while busy
    bus_wr(0, 8'h10);
    bus_wr(1, 8'h5A);
    bus_wr(2, 8'h04);
    bus_wr(2, 8'h02);
    stall_len(n);
    bus_wr(0, 8'h33);
    bus_wr(1, 8'hFF);
    bus_wr(2, 8'h01);
    chk("R7 read ignored stall", stall_o, 0);
    rd(0, v); chk("R7 addr locked", v, 8'h10);
    rd(1, v); chk("R7 data locked", v, 8'h5A);
    wait_idle(cyc);
    exp_mem[8'h10] = 8'h5A;
    do_read(8'h10, "R7 held byte committed");
    do_read(8'h33, "R7 other byte untouched");

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a;
      a = 8'($urandom);
      if ($urandom % 3 == 0) do_write(a, 8'($urandom), 1 + ($urandom % 5), "R3 rnd write");
      else                   do_read(a, "R6 rnd read");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule